// File: doc/BRIEF.md
# Constant-On-Time Switching Sequencer for a Synchronous Buck Stage

This block is the digital heart of a synchronous step-down controller that regulates by firing a fixed-width high-side pulse whenever the output sags. It receives single-bit flags from analog comparators and turns them into two registered gate enables, one for the high-side switch and one for the low-side switch. The inputs are output-below-reference, inductor-current zero crossing, valley over-current and reverse over-current.

A high-side pulse is a one-shot. Its width comes from a programmed cycle count plus a fixed adder, and it never drops below a floor. A new pulse is allowed only after a minimum high-side off interval and only while the valley current is below its limit. The two switches are separated by a dead interval in each direction. The block has two modes. In light-load skip mode, low-side conduction ends at the zero crossing. In forced-continuous mode, the zero crossing is ignored and only reverse over-current ends low-side conduction early. A disable input and an over-voltage clamp input override the sequence.

All durations are counted in clock cycles of the block clock. With a 10 ns tick, the defaults are: a 50 ns adder, a 110 ns floor, a 440 ns minimum off interval, 20 ns of dead time after high-side turn-off and 40 ns before high-side turn-on.

Top module: `cot_gate_seq`

## Requirements
- R1: While `en` is low at a clock edge, both `hs_gate` and `ls_gate` are low after that edge. Reset leaves both low.
- R2: `hs_gate` and `ls_gate` are never high in the same cycle.
- R3: An uninterrupted high-side pulse lasts exactly max(`ton_cyc` + ADD_CYC, MIN_ON_CYC) cycles, using the `ton_cyc` value sampled at the edge where the pulse starts.
- R4: Between two high-side pulses, `hs_gate` stays low for at least MIN_OFF_CYC cycles. With a new pulse requested continuously from low-side conduction, the low interval is exactly MIN_OFF_CYC + DT_LH_CYC cycles.
- R5: When the low side follows a high-side pulse, exactly DT_HL_CYC cycles pass with both gates low.
- R6: When a pulse is requested during low-side conduction, `ls_gate` falls and `hs_gate` rises exactly DT_LH_CYC cycles later.
- R7: In skip mode (`skip_mode` = 1), if `zc_det` is high while the low side conducts, `ls_gate` is low after the next edge. Both gates then stay low until a new pulse is requested.
- R8: In forced-continuous mode (`skip_mode` = 0), `zc_det` has no effect: the low side keeps conducting while no pulse is requested and `neg_oc` is low.
- R9: A high-side pulse is started only by an edge at which `fb_low` is 1 and `valley_oc` is 0. A pulse is withheld for as long as `valley_oc` stays high.
- R10: In forced-continuous mode, `neg_oc` high while the low side conducts turns `ls_gate` off at the next edge. Both gates then stay low until a new pulse is requested.
- R11: With `en` high and `force_ls` high at an edge, `ls_gate` is high and `hs_gate` is low after that edge, regardless of any other input. On release, both gates go low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; one tick per duration count |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Converter enable; low forces both gates off |
| force_ls | input | 1 | Over-voltage clamp: low side on, high side off |
| skip_mode | input | 1 | 1 = light-load skip, 0 = forced continuous |
| fb_low | input | 1 | Feedback comparator: output below reference |
| zc_det | input | 1 | Inductor current has reached zero |
| valley_oc | input | 1 | Valley current above positive limit |
| neg_oc | input | 1 | Reverse current beyond negative limit |
| ton_cyc | input | TON_W | Programmed on-time in cycles |
| hs_gate | output | 1 | High-side gate enable (registered) |
| ls_gate | output | 1 | Low-side gate enable (registered) |

## Verification
The bench targets the on-time floor at the values just below, at and above the point where the adder crosses it, as well as the largest programmed count. A design that compared on the wrong side of the floor, or sampled the count late, would produce pulses one cycle off. It holds a pulse request continuously, so the exact off interval and both dead intervals show up. An off-by-one in the off timer or the phase counter, or a trigger accepted during dead time, would shift them. The bench also holds the valley flag during a request, raises zero crossings in both modes, and switches to the clamp or to disable in mid-pulse. A design that mixed up the mode gating or the override priority would leave the low side on, drop it too early, or overlap the two gates.

// File: rtl/cot_pkg.sv
package cot_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DLH   = 3'd1,
    ST_HS    = 3'd2,
    ST_DHL   = 3'd3,
    ST_LS    = 3'd4,
    ST_CLAMP = 3'd5
  } cot_state_e;
endpackage

// File: rtl/cot_ontime.sv
module cot_ontime #(
  parameter int TON_W      = 8,
  parameter int ADD_CYC    = 5,
  parameter int MIN_ON_CYC = 11,
  localparam int CW        = TON_W + 1
) (
  input  logic [TON_W-1:0] ton_cyc,
  output logic [CW-1:0]    on_len
);
  logic [CW-1:0] raw_len;

  always_comb begin
    raw_len = {1'b0, ton_cyc} + CW'(ADD_CYC);
    if (raw_len < CW'(MIN_ON_CYC)) begin
      on_len = CW'(MIN_ON_CYC);
    end else begin
      on_len = raw_len;
    end
  end

  always_comb begin
    a_r3_floor_held: assert (on_len >= CW'(MIN_ON_CYC));
  end
endmodule

// File: rtl/cot_offtimer.sv
module cot_offtimer #(
  parameter int MIN_OFF_CYC = 44,
  localparam int OFFW       = $clog2(MIN_OFF_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic off_done
);
  logic [OFFW-1:0] cnt_q, cnt_d;
  logic            cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    if (load) begin
      cnt_d = OFFW'(MIN_OFF_CYC - 1);
    end else begin
      cnt_d = cnt_q - OFFW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign off_done = (cnt_q == '0);

  a_r4_reload_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !off_done);
endmodule

// File: rtl/cot_seq_fsm.sv
module cot_seq_fsm
  import cot_pkg::*;
#(
  parameter int TON_W     = 8,
  parameter int DT_HL_CYC = 2,
  parameter int DT_LH_CYC = 4,
  localparam int CW       = TON_W + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          force_ls,
  input  logic          skip_mode,
  input  logic          fb_low,
  input  logic          zc_det,
  input  logic          valley_oc,
  input  logic          neg_oc,
  input  logic          off_done,
  input  logic [CW-1:0] on_len,
  output logic          hs_leave,
  output logic          hs_q,
  output logic          ls_q
);
  localparam logic [CW-1:0] DLH_LOAD = CW'(DT_LH_CYC - 1);
  localparam logic [CW-1:0] DHL_LOAD = CW'(DT_HL_CYC - 1);

  cot_state_e    st_q, st_d;
  logic [CW-1:0] ph_q, ph_d;
  logic          trig;
  logic          ph_zero;
  logic          hs_d, ls_d;

  assign trig    = fb_low && !valley_oc && off_done;
  assign ph_zero = (ph_q == '0);

  always_comb begin
    st_d = st_q;
    ph_d = ph_q;
    if (!en) begin
      st_d = ST_IDLE;
      ph_d = '0;
    end else if (force_ls) begin
      st_d = ST_CLAMP;
      ph_d = '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (trig) begin
            st_d = ST_DLH;
            ph_d = DLH_LOAD;
          end
        end
        ST_DLH: begin
          if (ph_zero) begin
            st_d = ST_HS;
            ph_d = on_len - CW'(1);
          end else begin
            ph_d = ph_q - CW'(1);
          end
        end
        ST_HS: begin
          if (ph_zero) begin
            st_d = ST_DHL;
            ph_d = DHL_LOAD;
          end else begin
            ph_d = ph_q - CW'(1);
          end
        end
        ST_DHL: begin
          if (ph_zero) begin
            st_d = ST_LS;
          end else begin
            ph_d = ph_q - CW'(1);
          end
        end
        ST_LS: begin
          if (trig) begin
            st_d = ST_DLH;
            ph_d = DLH_LOAD;
          end else if (skip_mode && zc_det) begin
            st_d = ST_IDLE;
          end else if (!skip_mode && neg_oc) begin
            st_d = ST_IDLE;
          end
        end
        ST_CLAMP: begin
          st_d = ST_IDLE;
        end
        default: begin
          st_d = ST_IDLE;
          ph_d = '0;
        end
      endcase
    end
  end

  always_comb begin
    hs_d     = (st_d == ST_HS);
    ls_d     = (st_d == ST_LS) || (st_d == ST_CLAMP);
    hs_leave = (st_q == ST_HS) && (st_d != ST_HS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      ph_q <= '0;
      hs_q <= 1'b0;
      ls_q <= 1'b0;
    end else begin
      st_q <= st_d;
      ph_q <= ph_d;
      hs_q <= hs_d;
      ls_q <= ls_d;
    end
  end

  a_r1_disable_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!hs_q && !ls_q));
  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_q && ls_q));
  a_r5_gap_after_hs: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_q && en && !force_ls) |=> !ls_q);
  a_r6_gap_before_hs: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_q && en && !force_ls) |=> !hs_q);
  a_r7_skip_zero_cross: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_q && en && !force_ls && skip_mode && zc_det) |=> !ls_q);
  a_r10_reverse_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_q && en && !force_ls && !skip_mode && neg_oc) |=> !ls_q);
  a_r11_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    (en && force_ls) |=> (ls_q && !hs_q));
endmodule

// File: rtl/cot_gate_seq.sv
module cot_gate_seq #(
  parameter int TON_W       = 8,
  parameter int ADD_CYC     = 5,
  parameter int MIN_ON_CYC  = 11,
  parameter int MIN_OFF_CYC = 44,
  parameter int DT_HL_CYC   = 2,
  parameter int DT_LH_CYC   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             force_ls,
  input  logic             skip_mode,
  input  logic             fb_low,
  input  logic             zc_det,
  input  logic             valley_oc,
  input  logic             neg_oc,
  input  logic [TON_W-1:0] ton_cyc,
  output logic             hs_gate,
  output logic             ls_gate
);
  localparam int CW = TON_W + 1;

  logic [CW-1:0] on_len;
  logic          off_done;
  logic          hs_leave;

  cot_ontime #(
    .TON_W      (TON_W),
    .ADD_CYC    (ADD_CYC),
    .MIN_ON_CYC (MIN_ON_CYC)
  ) u_ontime (
    .ton_cyc (ton_cyc),
    .on_len  (on_len)
  );

  cot_offtimer #(
    .MIN_OFF_CYC (MIN_OFF_CYC)
  ) u_offtimer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (hs_leave),
    .off_done (off_done)
  );

  cot_seq_fsm #(
    .TON_W     (TON_W),
    .DT_HL_CYC (DT_HL_CYC),
    .DT_LH_CYC (DT_LH_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .force_ls  (force_ls),
    .skip_mode (skip_mode),
    .fb_low    (fb_low),
    .zc_det    (zc_det),
    .valley_oc (valley_oc),
    .neg_oc    (neg_oc),
    .off_done  (off_done),
    .on_len    (on_len),
    .hs_leave  (hs_leave),
    .hs_q      (hs_gate),
    .ls_q      (ls_gate)
  );

  a_r4_min_off_met: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_gate) |-> off_done);
  a_r9_valley_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!hs_gate && valley_oc && $past(valley_oc) && $past(valley_oc, 2)
     && $past(valley_oc, 3) && $past(valley_oc, 4) && $past(valley_oc, 5))
    |=> !hs_gate);
endmodule

// File: tb/cot_gate_seq_bench.sv
`timescale 1ns/100ps
module cot_gate_seq_bench;
  localparam int TON_W = 8, ADD = 5, MIN_ON = 11, MIN_OFF = 44, DT_HL = 2, DT_LH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, force_ls = 1'b0, skip_mode = 1'b0, fb_low = 1'b0;
  logic zc_det = 1'b0, valley_oc = 1'b0, neg_oc = 1'b0;
  logic [TON_W-1:0] ton_cyc = '0;
  logic hs_gate, ls_gate;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit exact = 1'b0;

  always #2.5 clk = ~clk;

  cot_gate_seq #(.TON_W(TON_W), .ADD_CYC(ADD), .MIN_ON_CYC(MIN_ON),
    .MIN_OFF_CYC(MIN_OFF), .DT_HL_CYC(DT_HL), .DT_LH_CYC(DT_LH)) u_cot_gate_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .force_ls(force_ls), .skip_mode(skip_mode),
    .fb_low(fb_low), .zc_det(zc_det), .valley_oc(valley_oc), .neg_oc(neg_oc),
    .ton_cyc(ton_cyc), .hs_gate(hs_gate), .ls_gate(ls_gate));

  function automatic int exp_on(input int t);
    return (t + ADD < MIN_ON) ? MIN_ON : t + ADD;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, expv);
    end
  endtask

  // monitor state
  bit p_ok = 0, p_en, p_force, pp_force, p_skip, p_zc, p_neg, p_trg, p_hs, p_ls;
  int p_ton, ton_rise, hs_hi_n, hs_low_n, ls_low_n;
  bit cut, fell_once;
  logic [DT_LH:0] trig_hist;

  always @(negedge clk) begin
    if (!rst_n) begin
      p_ok = 0; hs_hi_n = 0; hs_low_n = 0; ls_low_n = 0; cut = 0; fell_once = 0;
      trig_hist = '0; pp_force = 0; ton_rise = 0;
    end else begin
      chk(!(hs_gate && ls_gate), "R2 overlap", {hs_gate, ls_gate}, 0);
      if (p_ok) begin
        if (!p_en) chk(!hs_gate && !ls_gate, "R1 disable", {hs_gate, ls_gate}, 0);
        else if (p_force) chk(ls_gate && !hs_gate, "R11 clamp", {hs_gate, ls_gate}, 1);
        else if (p_ls) begin
          if (p_skip && p_zc) chk(!ls_gate, "R7 zero-cross stop", ls_gate, 0);
          else if (!p_skip && p_neg) chk(!ls_gate, "R10 reverse stop", ls_gate, 0);
          else if (!p_skip && p_zc && !p_trg && !pp_force)
            chk(ls_gate, "R8 zero-cross ignored", ls_gate, 1);
        end
        if (hs_gate && !p_hs) begin
          chk(trig_hist[DT_LH], "R9 trigger", trig_hist[DT_LH], 1);
          if (fell_once) chk(hs_low_n >= MIN_OFF, "R4 min off", hs_low_n, MIN_OFF);
          if (exact) begin
            chk(hs_low_n == MIN_OFF + DT_LH, "R4 exact off", hs_low_n, MIN_OFF + DT_LH);
            chk(ls_low_n == DT_LH, "R6 dead ls->hs", ls_low_n, DT_LH);
          end
          hs_hi_n = 0; cut = 0; ton_rise = p_ton;
        end
        if (!hs_gate && p_hs) begin
          fell_once = 1;
          if (!cut) chk(hs_hi_n == exp_on(ton_rise), "R3 width", hs_hi_n, exp_on(ton_rise));
        end
        if (ls_gate && !p_ls && !p_force && p_en)
          chk(hs_low_n == DT_HL, "R5 dead hs->ls", hs_low_n, DT_HL);
      end
      if (hs_gate) begin
        hs_hi_n++; hs_low_n = 0;
        if (!en || force_ls) cut = 1;
      end else hs_low_n++;
      if (ls_gate) ls_low_n = 0; else ls_low_n++;
      trig_hist = {trig_hist[DT_LH-1:0], fb_low && !valley_oc && en && !force_ls};
      pp_force = p_force;
      p_en = en; p_force = force_ls; p_skip = skip_mode; p_zc = zc_det; p_neg = neg_oc;
      p_trg = fb_low && !valley_oc; p_hs = hs_gate; p_ls = ls_gate; p_ton = int'(ton_cyc);
      p_ok = 1;
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wait_hs(input int lim, output bit got);
    got = 0;
    for (int i = 0; i < lim && !got; i++) begin @(negedge clk); got = hs_gate; end
    step(1);
  endtask

  task automatic wait_ls(input int lim, output bit got);
    got = 0;
    for (int i = 0; i < lim && !got; i++) begin @(negedge clk); got = ls_gate; end
    step(1);
  endtask

  task automatic exact_run(input int t, input int cyc);
    bit g;
    skip_mode = 0; fb_low = 1; valley_oc = 0; zc_det = 0; neg_oc = 0; ton_cyc = TON_W'(t);
    wait_hs(2000, g); chk(g, "R3 pulse seen", g, 1);
    step(exp_on(t) + 5);
    wait_hs(2000, g);
    exact = 1; step(cyc); exact = 0;
    fb_low = 0; step(exp_on(t) + 20);
  endtask

  initial begin
    bit g;
    bit seen;
    void'($urandom(32'd2718));
    step(3);
    @(negedge clk); chk(!hs_gate && !ls_gate, "R1 reset", {hs_gate, ls_gate}, 0);
    rst_n = 1; en = 1; step(20);
    @(negedge clk); chk(!hs_gate && !ls_gate, "R1 idle after reset", {hs_gate, ls_gate}, 0);
    step(1);

    // R3 floor boundaries and exact spacing (R4, R5, R6)
    exact_run(20, 300);
    exact_run(0, 200);
    exact_run(6, 200);
    exact_run(7, 200);
    exact_run(255, 700);

    // R8: zero crossing ignored in forced-continuous mode, then R10
    skip_mode = 0; ton_cyc = 10; fb_low = 1; wait_hs(500, g); fb_low = 0;
    wait_ls(200, g); chk(g, "R8 low side on", g, 1);
    zc_det = 1; step(100);
    @(negedge clk); chk(ls_gate && !hs_gate, "R8 ls held with zc", ls_gate, 1);
    step(1); zc_det = 0; neg_oc = 1;
    @(negedge clk); @(negedge clk); chk(!ls_gate, "R10 reverse cut", ls_gate, 0);
    step(1); neg_oc = 0; step(50);
    @(negedge clk); chk(!ls_gate && !hs_gate, "R10 stays off", {hs_gate, ls_gate}, 0);
    step(1);

    // R7: skip mode zero crossing
    skip_mode = 1; fb_low = 1; wait_hs(500, g); fb_low = 0;
    wait_ls(200, g); chk(g, "R7 low side on", g, 1);
    zc_det = 1;
    @(negedge clk); @(negedge clk); chk(!ls_gate, "R7 ls off at zc", ls_gate, 0);
    step(1); zc_det = 0; step(60);
    @(negedge clk); chk(!ls_gate && !hs_gate, "R7 both off until trigger", {hs_gate, ls_gate}, 0);
    step(1); fb_low = 1; wait_hs(100, g); chk(g, "R7 resumes on trigger", g, 1);
    fb_low = 0; step(100);

    // R9: valley limit withholds pulses
    valley_oc = 1; fb_low = 1; seen = 0;
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (hs_gate) seen = 1; end
    chk(!seen, "R9 withheld under valley limit", seen, 0);
    step(1); valley_oc = 0; wait_hs(100, g); chk(g, "R9 released", g, 1);
    fb_low = 0; step(100);

    // R11 clamp and R1 disable in mid pulse
    ton_cyc = 100; fb_low = 1; wait_hs(200, g); force_ls = 1;
    @(negedge clk); @(negedge clk); chk(ls_gate && !hs_gate, "R11 clamp mid pulse", {hs_gate, ls_gate}, 1);
    step(20); fb_low = 0; force_ls = 0;
    @(negedge clk); @(negedge clk); chk(!ls_gate && !hs_gate, "R11 release", {hs_gate, ls_gate}, 0);
    step(1); fb_low = 1; wait_hs(200, g); en = 0;
    @(negedge clk); @(negedge clk); chk(!ls_gate && !hs_gate, "R1 disable mid pulse", {hs_gate, ls_gate}, 0);
    step(30);
    @(negedge clk); chk(!ls_gate && !hs_gate, "R1 held off", {hs_gate, ls_gate}, 0);
    step(1); en = 1; fb_low = 0; step(100);

    // random phase
    for (int s = 0; s < 40; s++) begin
      skip_mode = 1'($urandom % 2);
      ton_cyc = TON_W'($urandom % 48);
      for (int c = 0; c < 400; c++) begin
        fb_low    = ($urandom % 3) == 0;
        zc_det    = ($urandom % 8) == 0;
        valley_oc = ($urandom % 10) == 0;
        neg_oc    = ($urandom % 16) == 0;
        en        = ($urandom % 200) != 0;
        force_ls  = ($urandom % 300) == 0;
        step(1);
      end
    end
    en = 1; force_ls = 0; fb_low = 0; step(20);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R1 watchdog: actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule